// File: doc/BRIEF.md
# SIMD Shift-Left-by-Immediate Execute Unit

This unit executes the vector shift-left-by-immediate instruction family. Each cycle it may take a 32-bit instruction word and a 128-bit source vector. It decodes either a same-width shift or a widening shift. In the widening shift each lane is sign- or zero-extended to twice its width and then shifted. One cycle later it presents the 128-bit result, the destination register index and an illegal-encoding flag.

A 7-bit immediate field in bits 22..16 sets both the lane width and the shift amount. The position of its leading one selects the lane width, and the bits below that one give the shift count. The register file supplies the source vector. The unit presents the source register index from bits 9..5 combinationally as a read address. It does no fetch and no hazard tracking.

Top module: `simd_shl_imm_unit`

## Requirements
- R1: While rst_n is low, out_valid, result, dest_index and illegal are all zero.
- R2: out_valid is high in the cycle after a cycle with in_valid high, and low otherwise. result, illegal and dest_index keep their values through cycles without a strobe.
- R3: The lane width is set by the highest set bit of imm = instr[22:16]. Bit 3 gives 8 bits, bit 4 gives 16, bit 5 gives 32 and bit 6 gives 64. The shift is imm minus the lane width. The encodings 0x0F0BA420, 0x4F435420 and 0x6F0BA420 decode as: signed 8-to-16 widen by 3; 64-bit plain shift by 3; unsigned upper-half 8-to-16 widen by 3. The last two have destination 0.
- R4: A plain shift is opcode instr[15:11]=01010 with U=instr[29]=0. It shifts every lane left, and bits that leave a lane are lost. With Q=instr[30]=0 only the low 64 bits are processed and result[127:64] is zero.
- R5: A plain shift with 64-bit lanes is legal only when Q=1.
- R6: A widening shift is opcode 10100. With U=0 each source lane is sign-extended to double width and then shifted. A shift of 0 gives pure extension.
- R7: A widening shift with U=1 zero-extends each source lane before the shift.
- R8: A widening shift takes its lanes from src_vec[63:0] when Q=0 and from src_vec[127:64] when Q=1. The result always fills 128 bits.
- R9: illegal is raised and result is all zero in each of these cases:
  - instr[31] is not 0, instr[28:23] is not 011110, or instr[10] is not 1;
  - imm[6:3] is zero;
  - the opcode/U pair is anything else;
  - the shift is widening and imm[6] is set;
  - the shift is plain with 64-bit lanes and Q=0.
- R10: dest_index is the registered instr[4:0]. src_index equals instr[9:5] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: instr and src_vec are valid this cycle |
| instr | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector read from the register file |
| src_index | output | 5 | Source register index, instr[9:5] |
| out_valid | output | 1 | Result is valid, one cycle after in_valid |
| result | output | 128 | Shifted vector |
| dest_index | output | 5 | Destination register index |
| illegal | output | 1 | Encoding is not a supported form |

## Verification
The assertions check several rules on every cycle:
- out_valid follows the strobe by exactly one cycle;
- the output registers hold through idle cycles;
- an illegal result is always zero;
- the destination index tracks the strobed word;
- a decoded shift never reaches its lane width;
- a narrow plain shift leaves the upper half clear.

The lane arithmetic can only be shown by the bench's sweeps. This covers the sign or zero fill of each lane, the choice of source half and the loss of bits that leave a lane. The sweeps run every immediate value for every opcode, U and Q combination. The source patterns include all-ones and negative lanes. The sweeps also cover every other opcode and each corrupted fixed bit.

// File: rtl/shl_pkg.sv
package shl_pkg;
  localparam int unsigned CTL_W = 22;
  localparam int unsigned IDX_W = 5;
  localparam int unsigned NSIZE = 4;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PLAIN = 2'd1,
    OP_WIDEN = 2'd2
  } shl_op_e;

  typedef struct packed {
    shl_op_e    op;
    logic       q;
    logic       zext;
    logic [1:0] size;
    logic [5:0] amt;
    logic       bad;
  } shl_ctl_t;
endpackage

// File: rtl/shl_decode.sv
module shl_decode
  import shl_pkg::*;
(
  input  logic [CTL_W-1:0] ctl_bits,
  output shl_ctl_t         ctl
);
  logic [6:0] imm;
  logic [4:0] opc;
  logic       fixed_ok;
  logic       size_ok;
  logic       is_plain;
  logic       is_widen;

  assign imm      = ctl_bits[12:6];
  assign opc      = ctl_bits[5:1];
  assign fixed_ok = (ctl_bits[21] == 1'b0) && (ctl_bits[18:13] == 6'b011110) && ctl_bits[0];
  assign is_plain = (opc == 5'b01010) && !ctl_bits[19];
  assign is_widen = (opc == 5'b10100);

  always_comb begin
    ctl.q    = ctl_bits[20];
    ctl.zext = ctl_bits[19];
    ctl.size = 2'd0;
    ctl.amt  = 6'd0;
    size_ok  = 1'b1;
    if (imm[6]) begin
      ctl.size = 2'd3;
      ctl.amt  = imm[5:0];
    end else if (imm[5]) begin
      ctl.size = 2'd2;
      ctl.amt  = {1'b0, imm[4:0]};
    end else if (imm[4]) begin
      ctl.size = 2'd1;
      ctl.amt  = {2'b00, imm[3:0]};
    end else if (imm[3]) begin
      ctl.size = 2'd0;
      ctl.amt  = {3'b000, imm[2:0]};
    end else begin
      size_ok  = 1'b0;
    end
    ctl.op  = is_plain ? OP_PLAIN : (is_widen ? OP_WIDEN : OP_NONE);
    ctl.bad = !fixed_ok || !size_ok || !(is_plain || is_widen)
            || (is_plain && (ctl.size == 2'd3) && !ctl_bits[20])
            || (is_widen && (ctl.size == 2'd3));
  end

  // R3: a legal decode never shifts by the full lane width
  always_comb begin
    if (!ctl.bad) begin
      a_r3_amt_in_lane: assert (int'(ctl.amt) < (8 << ctl.size));
    end
  end
endmodule

// File: rtl/shl_lane_engine.sv
module shl_lane_engine
  import shl_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0] src_vec,
  input  shl_ctl_t         ctl,
  output logic [VEC_W-1:0] res
);
  localparam int unsigned HALF_W = VEC_W / 2;

  logic [VEC_W-1:0]  plain_by_size [NSIZE];
  logic [VEC_W-1:0]  widen_by_size [NSIZE];
  logic [HALF_W-1:0] half_src;

  assign half_src = ctl.q ? src_vec[VEC_W-1:HALF_W] : src_vec[HALF_W-1:0];

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int unsigned LW  = 8 << s;
    localparam int unsigned NL  = VEC_W / LW;
    localparam int unsigned NWL = HALF_W / LW;

    for (genvar l = 0; l < NL; l++) begin : g_plain
      assign plain_by_size[s][l*LW +: LW] = src_vec[l*LW +: LW] << ctl.amt;
    end

    if (s < NSIZE - 1) begin : g_wide
      for (genvar l = 0; l < NWL; l++) begin : g_lane
        logic [LW-1:0]   lane;
        logic [2*LW-1:0] ext;
        assign lane = half_src[l*LW +: LW];
        assign ext  = {{LW{!ctl.zext & lane[LW-1]}}, lane};
        assign widen_by_size[s][l*2*LW +: 2*LW] = ext << ctl.amt;
      end
    end else begin : g_nowide
      assign widen_by_size[s] = '0;
    end
  end

  always_comb begin
    res = '0;
    if (!ctl.bad) begin
      if (ctl.op == OP_PLAIN) begin
        res = ctl.q ? plain_by_size[ctl.size]
                    : {{HALF_W{1'b0}}, plain_by_size[ctl.size][HALF_W-1:0]};
      end else if (ctl.op == OP_WIDEN) begin
        res = widen_by_size[ctl.size];
      end
    end
  end

  // R4: narrow plain form leaves the upper half clear
  always_comb begin
    if (!ctl.bad && (ctl.op == OP_PLAIN) && !ctl.q) begin
      a_r4_upper_clear: assert (res[VEC_W-1:HALF_W] == '0);
    end
  end
endmodule

// File: rtl/simd_shl_imm_unit.sv
module simd_shl_imm_unit
  import shl_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      instr,
  input  logic [VEC_W-1:0] src_vec,
  output logic [IDX_W-1:0] src_index,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic [IDX_W-1:0] dest_index,
  output logic             illegal
);
  shl_ctl_t         ctl;
  logic [VEC_W-1:0] res_d;

  logic             vld_q, vld_n;
  logic [VEC_W-1:0] res_q, res_n;
  logic [IDX_W-1:0] dst_q, dst_n;
  logic             ill_q, ill_n;

  assign src_index = instr[9:5];

  shl_decode u_dec (
    .ctl_bits (instr[31:10]),
    .ctl      (ctl)
  );

  shl_lane_engine #(.VEC_W(VEC_W)) u_eng (
    .src_vec (src_vec),
    .ctl     (ctl),
    .res     (res_d)
  );

  always_comb begin
    vld_n = in_valid;
    res_n = res_q;
    dst_n = dst_q;
    ill_n = ill_q;
    if (in_valid) begin
      res_n = res_d;
      dst_n = instr[IDX_W-1:0];
      ill_n = ctl.bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      dst_q <= '0;
      ill_q <= 1'b0;
    end else begin
      vld_q <= vld_n;
      res_q <= res_n;
      dst_q <= dst_n;
      ill_q <= ill_n;
    end
  end

  assign out_valid  = vld_q;
  assign result     = res_q;
  assign dest_index = dst_q;
  assign illegal    = ill_q;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(illegal) && $stable(dest_index)));
  a_r9_zero_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == '0));
  a_r10_dest_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (dest_index == $past(instr[IDX_W-1:0])));
endmodule

// File: tb/simd_shl_imm_unit_tb_top.sv
module simd_shl_imm_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  instr;
  logic [127:0] src_vec;
  logic [4:0]   src_index;
  logic         out_valid;
  logic [127:0] result;
  logic [4:0]   dest_index;
  logic         illegal;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  simd_shl_imm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_vec(src_vec), .src_index(src_index), .out_valid(out_valid),
    .result(result), .dest_index(dest_index), .illegal(illegal)
  );

  function automatic logic [31:0] enc(bit q, bit u, bit [4:0] opc, bit [6:0] imm,
                                      bit [4:0] rn, bit [4:0] rd);
    return {1'b0, q, u, 6'b011110, imm, opc, 1'b1, rn, rd};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic model(input logic [31:0] ins, input logic [127:0] s,
                       output logic [127:0] r, output bit ill, output string tag);
    bit q, u, plain, widen;
    int imm, lw, sh, off;
    q = ins[30]; u = ins[29];
    imm = int'(ins[22:16]);
    lw = 0;
    for (int w = 64; w >= 8; w = w / 2) if (lw == 0 && imm >= w) lw = w;
    sh = imm - lw;
    plain = (ins[15:11] == 5'd10) && !u;
    widen = (ins[15:11] == 5'd20);
    ill = ins[31] || (ins[28:23] != 6'd30) || !ins[10] || (lw == 0) || !(plain || widen)
       || (plain && lw == 64 && !q) || (widen && lw == 64);
    r = '0;
    if (!ill && plain) begin
      for (int i = 0; i < (q ? 128 : 64); i++) begin
        int base = (i / lw) * lw;
        int pos  = i - base;
        r[i] = (pos >= sh) ? s[base + pos - sh] : 1'b0;
      end
    end else if (!ill) begin
      off = q ? 64 : 0;
      for (int i = 0; i < 128; i++) begin
        int lane = i / (2 * lw);
        int pos  = i % (2 * lw);
        if (pos < sh) r[i] = 1'b0;
        else if (pos - sh < lw) r[i] = s[off + lane*lw + pos - sh];
        else r[i] = u ? 1'b0 : s[off + lane*lw + lw - 1];
      end
    end
    if (ill) tag = "R9";
    else if (plain) tag = (lw == 64) ? "R3,R5" : "R3,R4";
    else tag = {u ? "R3,R7" : "R3,R6", q ? ",R8" : ""};
  endtask

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] ins, logic [127:0] s);
    logic [127:0] er;
    bit           ei;
    string        tag;
    model(ins, s, er, ei, tag);
    @(negedge clk);
    instr = ins; src_vec = s; in_valid = 1'b1;
    #1;
    chk("R10", "src_index", 128'(src_index), 128'(ins[9:5]));
    @(negedge clk);
    n_vec++;
    chk("R2", "out_valid", 128'(out_valid), 128'(1'b1));
    chk(tag, "result", result, er);
    chk(tag, "illegal", 128'(illegal), 128'(ei));
    chk("R10", "dest_index", 128'(dest_index), 128'(ins[4:0]));
    in_valid = 1'b0; instr = $urandom(); src_vec = rnd128();
    @(negedge clk);
    chk("R2", "idle out_valid", 128'(out_valid), 128'(1'b0));
    chk("R2", "held result", result, er);
    chk("R2", "held illegal", 128'(illegal), 128'(ei));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired actual %0d expected <150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] pat;
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; src_vec = '0;
    repeat (3) @(negedge clk);
    n_vec++;
    chk("R1", "reset out_valid", 128'(out_valid), 128'(0));
    chk("R1", "reset result", result, 128'(0));
    chk("R1", "reset illegal", 128'(illegal), 128'(0));
    chk("R1", "reset dest_index", 128'(dest_index), 128'(0));
    rst_n = 1'b1;

    // R3 reference encodings
    apply(32'h0F0BA420, rnd128());
    apply(32'h0F0BA420, {16{8'hF3}});
    apply(32'h4F435420, rnd128());
    apply(32'h6F0BA420, {16{8'h9C}});

    // Full immediate sweep for every legal opcode/U/Q combination
    for (int op = 0; op < 3; op++) begin
      for (int q = 0; q < 2; q++) begin
        for (int imm = 0; imm < 128; imm++) begin
          for (int k = 0; k < 4; k++) begin
            bit       u   = (op == 2);
            bit [4:0] opc = (op == 0) ? 5'b01010 : 5'b10100;
            case (k)
              0, 1:    pat = rnd128();
              2:       pat = {16{8'h81}};
              default: pat = '1;
            endcase
            apply(enc(q[0], u, opc, imm[6:0], 5'($urandom()), 5'($urandom())), pat);
          end
        end
      end
    end

    // R9 other opcode/U pairs
    for (int opc = 0; opc < 32; opc++) begin
      for (int u = 0; u < 2; u++) begin
        if (!((opc == 10 && u == 0) || opc == 20))
          apply(enc(1'b1, u[0], opc[4:0], 7'b0101011, 5'd3, 5'd7), rnd128());
      end
    end

    // R9 corrupted fixed bits
    apply(enc(1'b1, 1'b0, 5'b01010, 7'b0011010, 5'd1, 5'd2) | 32'h8000_0000, rnd128());
    apply(enc(1'b1, 1'b0, 5'b01010, 7'b0011010, 5'd1, 5'd2) & ~32'h0000_0400, rnd128());
    for (int b = 23; b < 29; b++)
      apply(enc(1'b1, 1'b1, 5'b10100, 7'b0010001, 5'd4, 5'd9) ^ (32'd1 << b), rnd128());

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule